// File: doc/BRIEF.md
# Serial EEPROM Command Controller

This block models the command side of a byte-organized serial EEPROM with 512 bytes of storage. A host frames each command with chip select high. While the frame is open, the host clocks bits in on a serial data input, most significant bit first. Every command begins with an opcode byte. Memory commands then take a high address byte and a low address byte. A write also takes one data byte.

The block decodes six commands:

- read
- write
- erase of one byte
- chip clear, which has to be entered twice in a row
- a one-shot override of write protection
- an enable for ready/busy reporting

Write, erase and chip clear each start a self-timed cycle. Its length is a parameter counted in system clocks. While the cycle runs, the block ignores any new command.

The serial output has its own output enable, so the pin floats when the block is not driving it. The output carries read data during a read. Once reporting has been enabled, it also carries the ready/busy state. All serial inputs are sampled in the system clock domain. The serial clock must therefore stay high and low for several system clocks in each phase.

Top module: `ser_eeprom_ctrl`

## Requirements
- R1: Bits are taken MSB first on rising serial clock edges while chip select is high. The frame is opcode, then high address byte, then low address byte. Only bit 0 of the high byte is used, so address = {high[0], low}, which wraps modulo 512.
- R2: Opcode 0xC9 (read) drives the addressed byte out MSB first, with sdo_oe high throughout. Bit 7 is valid before the 25th rising edge. Each later falling edge presents the next bit. After the 32nd falling edge the output stops driving read data.
- R3: Opcode 0xC1 (write) stores its data byte at the address and starts a self-timed cycle of PROG_CYCLES clocks.
- R4: Opcode 0xC0 (erase) sets the addressed byte to 0xFF and starts a self-timed cycle.
- R5: Opcode 0x89 (chip clear) sets all 512 bytes to 0xFF only when it is entered in two back-to-back frames. A single entry does nothing. Any other opcode between the two entries cancels the first entry.
- R6: Protection is active after reset. Write, erase and chip clear do nothing unless opcode 0x83 (override) was the immediately preceding command. For chip clear, the override must precede the first entry.
- R7: The override applies to exactly one following command, whatever its opcode, and is used up by it.
- R8: Opcode 0x81 enables status reporting until reset. Once it is enabled, sdo_oe is high with sdo low during a self-timed cycle. When no cycle runs and chip select is low, sdo_oe and sdo are both high.
- R9: Without status reporting, sdo_oe is low except while read data is being driven.
- R10: Any frame that clocks a bit in while a self-timed cycle is running is discarded entirely.
- R11: Lowering chip select before a command is complete discards it. The next frame starts again with an opcode.
- R12: After reset every byte reads 0xFF and sdo_oe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Chip select, high frames a command |
| sclk | input | 1 | Serial clock, oversampled by clk |
| sdi | input | 1 | Serial data input |
| sdo | output | 1 | Serial data output (read data or status) |
| sdo_oe | output | 1 | Output enable for sdo; low means high impedance |

## Verification
The bench goes after the protection corner cases:

- an override followed by two writes; a design that kept the override alive would wrongly store the second byte
- an unknown opcode placed between the override and a write; a design that kept the override alive here would also store the byte
- a chip clear interrupted by another command; a design that forgot to cancel the first entry would wipe the whole array

It also checks the frame edge cases:

- a high address byte of 0xFE; a design with a wrong address width would write outside the expected byte
- a frame sent during a self-timed cycle; a design that dropped only the opcode would corrupt later data
- a partial frame cut off by chip select; a design that did not restart its bit count would leave later frames misaligned

With status reporting off, the bench also checks that the output never drives during a cycle. With it on, it checks that the busy-low window lasts about PROG_CYCLES clocks.

// File: rtl/seep_pkg.sv
// Package: shared opcodes and state encodings for the serial EEPROM controller.
// Assumes byte organization only; opcode values are fixed by the command set.
package seep_pkg;
    localparam logic [7:0] OP_READ   = 8'hC9;
    localparam logic [7:0] OP_WRITE  = 8'hC1;
    localparam logic [7:0] OP_ERASE  = 8'hC0;
    localparam logic [7:0] OP_CLRALL = 8'h89;
    localparam logic [7:0] OP_UNLOCK = 8'h83;
    localparam logic [7:0] OP_STATEN = 8'h81;

    typedef enum logic [2:0] {
        ST_OPC,
        ST_ADRH,
        ST_ADRL,
        ST_DATA,
        ST_SHOUT,
        ST_DONE,
        ST_VOID
    } fsm_t;

    typedef enum logic [1:0] {
        K_NONE,
        K_READ,
        K_WRITE,
        K_ERASE
    } kind_t;
endpackage

// File: rtl/seep_bit_rx.sv
// Module: serial bit receiver. Oversamples sclk with clk, detects its edges
// while cs is high and assembles W-bit words MSB first. byte_vld pulses one
// clock after the rise edge that completed a word.
// Assumes sclk and sdi are stable for several clk periods per phase.
module seep_bit_rx #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs,
    input  logic         sclk,
    input  logic         sdi,
    output logic         rise,
    output logic         fall,
    output logic         byte_vld,
    output logic [W-1:0] byte_val
);
    localparam int CW = $clog2(W);

    logic          sclk_q;
    logic [CW-1:0] bit_cnt;
    logic [W-1:0]  sr;

    // Edge detection against the previous clk sample of sclk.
    assign rise = cs & sclk & ~sclk_q;
    assign fall = cs & ~sclk & sclk_q;
    assign byte_val = sr;

    // Shift register and bit counter; counter restarts whenever cs is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q   <= 1'b0;
            bit_cnt  <= '0;
            sr       <= '0;
            byte_vld <= 1'b0;
        end else begin
            sclk_q   <= sclk;
            byte_vld <= 1'b0;
            if (!cs) begin
                bit_cnt <= '0;
            end else if (rise) begin
                sr       <= {sr[W-2:0], sdi};
                byte_vld <= (bit_cnt == CW'(W-1));
                bit_cnt  <= (bit_cnt == CW'(W-1)) ? '0 : bit_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/seep_cycle_timer.sv
// Module: self-timed program/erase cycle counter. A start pulse loads CYCLES
// and busy stays high until the count drains to zero.
// Assumes start is only raised while busy is low.
module seep_cycle_timer #(
    parameter int CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt;

    assign busy = (cnt != '0);

    // Load on start, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= CW'(CYCLES);
        end else if (busy) begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/seep_store.sv
// Module: byte storage array with one write port, one combinational read
// port and a whole-array clear. Every cell resets to all ones (erased).
// Assumes clr_all and we are not raised together.
module seep_store #(
    parameter int DEPTH = 512,
    parameter int W     = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [W-1:0]             wdata,
    input  logic                     clr_all,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [W-1:0]             rdata
);
    logic [W-1:0] cells [DEPTH];

    assign rdata = cells[raddr];

    // Cell update: reset or clear to ones, else single-byte write.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= '1;
            end
        end else if (we) begin
            cells[waddr] <= wdata;
        end
    end
endmodule

// File: rtl/ser_eeprom_ctrl.sv
// Module: serial EEPROM command controller (top). Decodes opcode, address
// and data bytes from the receiver, applies protection, the one-shot
// override and the two-entry chip clear, runs reads out on sdo and reports
// ready/busy once enabled. Assumes DEPTH > 256 so a high address byte is used.
module ser_eeprom_ctrl #(
    parameter int DEPTH       = 512,
    parameter int PROG_CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sclk,
    input  logic sdi,
    output logic sdo,
    output logic sdo_oe
);
    import seep_pkg::*;

    localparam int AW = $clog2(DEPTH);
    localparam int HW = AW - 8;

    fsm_t          state;
    kind_t         kind;
    logic [HW-1:0] addr_hi;
    logic [7:0]    addr_lo;
    logic          lift;
    logic          armed;
    logic          allowed;
    logic          stat_en_q;
    logic [7:0]    rd_sr;
    logic [2:0]    rd_cnt;
    logic          rd_skip;

    logic          rx_rise, rx_fall, rx_vld;
    logic [7:0]    rx_byte;
    logic          busy;
    logic          mem_we, mem_clr, tmr_start, reading;
    logic [AW-1:0] waddr, raddr;
    logic [7:0]    wdata, rdata;

    seep_bit_rx #(.W(8)) u_rx (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sclk(sclk), .sdi(sdi),
        .rise(rx_rise), .fall(rx_fall), .byte_vld(rx_vld), .byte_val(rx_byte)
    );

    seep_cycle_timer #(.CYCLES(PROG_CYCLES)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start(tmr_start), .busy(busy)
    );

    seep_store #(.DEPTH(DEPTH), .W(8)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(waddr), .wdata(wdata),
        .clr_all(mem_clr), .raddr(raddr), .rdata(rdata)
    );

    // Memory actions decided in the cycle a byte completes.
    always_comb begin
        mem_we  = cs && !busy && rx_vld && allowed &&
                  ((state == ST_DATA && kind == K_WRITE) ||
                   (state == ST_ADRL && kind == K_ERASE));
        mem_clr = cs && !busy && rx_vld && state == ST_OPC &&
                  rx_byte == OP_CLRALL && armed;
        tmr_start = mem_we || mem_clr;
        wdata   = (state == ST_DATA) ? rx_byte : 8'hFF;
        waddr   = {addr_hi, (state == ST_DATA) ? addr_lo : rx_byte};
        raddr   = {addr_hi, rx_byte};
    end

    // Output pin: read data while shifting out, else status when enabled.
    always_comb begin
        reading = (state == ST_SHOUT);
        sdo_oe  = reading || (stat_en_q && (busy || !cs));
        sdo     = reading ? rd_sr[7] : !busy;
    end

    // Command sequencer: frame state, protection flags and read shifter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_OPC;
            kind      <= K_NONE;
            addr_hi   <= '0;
            addr_lo   <= '0;
            lift      <= 1'b0;
            armed     <= 1'b0;
            allowed   <= 1'b0;
            stat_en_q <= 1'b0;
            rd_sr     <= '0;
            rd_cnt    <= '0;
            rd_skip   <= 1'b0;
        end else if (!cs) begin
            state   <= ST_OPC;
            rd_cnt  <= '0;
            rd_skip <= 1'b0;
        end else if (busy && rx_rise) begin
            state <= ST_VOID;
        end else begin
            case (state)
                ST_OPC: if (rx_vld) begin
                    lift    <= (rx_byte == OP_UNLOCK);
                    armed   <= (rx_byte == OP_CLRALL) && !armed && lift;
                    allowed <= lift;
                    case (rx_byte)
                        OP_READ:  begin kind <= K_READ;  state <= ST_ADRH; end
                        OP_WRITE: begin kind <= K_WRITE; state <= ST_ADRH; end
                        OP_ERASE: begin kind <= K_ERASE; state <= ST_ADRH; end
                        OP_STATEN: begin stat_en_q <= 1'b1; state <= ST_DONE; end
                        default:  begin kind <= K_NONE;  state <= ST_DONE; end
                    endcase
                end
                ST_ADRH: if (rx_vld) begin
                    addr_hi <= rx_byte[HW-1:0];
                    state   <= ST_ADRL;
                end
                ST_ADRL: if (rx_vld) begin
                    addr_lo <= rx_byte;
                    if (kind == K_READ) begin
                        rd_sr   <= rdata;
                        rd_cnt  <= '0;
                        rd_skip <= 1'b1;
                        state   <= ST_SHOUT;
                    end else if (kind == K_WRITE) begin
                        state <= ST_DATA;
                    end else begin
                        state <= ST_DONE;
                    end
                end
                ST_DATA: if (rx_vld) begin
                    state <= ST_DONE;
                end
                ST_SHOUT: if (rx_fall) begin
                    if (rd_skip) begin
                        rd_skip <= 1'b0;
                    end else if (rd_cnt == 3'd7) begin
                        state <= ST_DONE;
                    end else begin
                        rd_sr  <= {rd_sr[6:0], 1'b0};
                        rd_cnt <= rd_cnt + 1'b1;
                    end
                end
                default: state <= state;
            endcase
        end
    end
endmodule

// File: rtl/seep_checker.sv
// Module: property checker for ser_eeprom_ctrl, attached with bind.
// Assumes it observes the top-level pins plus sequencer and timer signals.
module seep_checker (
    input logic clk,
    input logic rst_n,
    input logic cs,
    input logic sdo,
    input logic sdo_oe,
    input logic busy,
    input logic stat_en,
    input logic reading,
    input logic mem_we,
    input logic mem_clr
);
    // R8: status enabled and cycle running means the pin drives low.
    a_r8_busy_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_en && busy) |-> (sdo_oe && !sdo));

    // R8: status enabled, idle and deselected means the pin drives high.
    a_r8_ready_high: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_en && !busy && !cs) |-> (sdo_oe && sdo));

    // R9: without status reporting the pin floats unless read data is out.
    a_r9_float_without_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_en && !reading) |-> !sdo_oe);

    // R10: no memory change may begin while a cycle runs.
    a_r10_no_update_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(mem_we || mem_clr));

    // R3: every memory change is followed by a running cycle.
    a_r3_update_starts_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_clr) |=> busy);
endmodule

bind ser_eeprom_ctrl seep_checker u_seep_checker (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sdo(sdo), .sdo_oe(sdo_oe),
    .busy(busy), .stat_en(stat_en_q), .reading(reading),
    .mem_we(mem_we), .mem_clr(mem_clr)
);

// File: tb/test_ser_eeprom_ctrl.sv
// Bench: behavioural byte-array reference model; serial frames driven from
// tasks, outputs sampled 1 ns after clock edges.
module test_ser_eeprom_ctrl;
    localparam int PROG = 400;

    logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sclk = 1'b0, sdi = 1'b0;
    logic sdo, sdo_oe;
    int   n_chk = 0, n_fail = 0;
    logic [7:0] mem_m [0:511];

    always #10 clk = ~clk;

    ser_eeprom_ctrl #(.DEPTH(512), .PROG_CYCLES(PROG)) i_ser_eeprom_ctrl (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sclk(sclk), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic xfer(input logic b, output logic o, output logic oe);
        sdi = b;
        tick(4);
        o  = sdo;
        oe = sdo_oe;
        sclk = 1'b1;
        tick(4);
        sclk = 1'b0;
    endtask

    task automatic put_byte(input logic [7:0] v);
        logic o, e;
        for (int i = 7; i >= 0; i--) xfer(v[i], o, e);
    endtask

    task automatic begin_f;
        cs = 1'b1;
        tick(2);
    endtask

    task automatic end_f;
        tick(2);
        cs = 1'b0;
        tick(3);
    endtask

    task automatic op(input logic [7:0] c);
        begin_f; put_byte(c); end_f;
    endtask

    task automatic cmd3(input logic [7:0] c, input logic [7:0] ah, input logic [7:0] al);
        begin_f; put_byte(c); put_byte(ah); put_byte(al); end_f;
    endtask

    task automatic wr(input logic [7:0] ah, input logic [7:0] al, input logic [7:0] d);
        begin_f; put_byte(8'hC1); put_byte(ah); put_byte(al); put_byte(d); end_f;
    endtask

    task automatic rd(input logic [7:0] ah, input logic [7:0] al, input string req);
        logic [7:0] v;
        logic o, e;
        bit oe_all;
        oe_all = 1'b1;
        begin_f;
        put_byte(8'hC9); put_byte(ah); put_byte(al);
        for (int i = 7; i >= 0; i--) begin
            xfer(1'b0, o, e);
            v[i] = o;
            if (e !== 1'b1) oe_all = 1'b0;
        end
        check(oe_all, "R2 sdo_oe during read", oe_all, 1);
        check(v === mem_m[{ah[0], al}], req, v, mem_m[{ah[0], al}]);
        end_f;
    endtask

    task automatic wait_cycle;
        tick(PROG + 20);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int cnt;
        bit any_oe;
        for (int i = 0; i < 512; i++) mem_m[i] = 8'hFF;
        tick(5);
        rst_n = 1'b1;
        tick(2);

        // R12: reset state floats, memory erased
        check(sdo_oe == 1'b0, "R12 sdo_oe after reset", sdo_oe, 0);
        rd(8'h00, 8'h05, "R12 erased after reset");
        check(sdo_oe == 1'b0, "R9 float after read", sdo_oe, 0);

        // R6: write without override blocked
        wr(8'h00, 8'h05, 8'h3C);
        wait_cycle;
        rd(8'h00, 8'h05, "R6 write blocked while protected");

        // R3 + R9: permitted write, pin floats during cycle
        op(8'h83);
        wr(8'h00, 8'h05, 8'h3C);
        mem_m[9'h005] = 8'h3C;
        any_oe = 1'b0;
        for (int i = 0; i < PROG + 20; i++) begin
            tick(1);
            if (sdo_oe !== 1'b0) any_oe = 1'b1;
        end
        check(!any_oe, "R9 no drive during cycle without enable", any_oe, 0);
        rd(8'h00, 8'h05, "R3 write stored");

        // R1: high address byte bit 0 selects upper half
        op(8'h83);
        wr(8'h01, 8'hA0, 8'h5A);
        mem_m[9'h1A0] = 8'h5A;
        wait_cycle;
        rd(8'h01, 8'hA0, "R1 upper half address");
        rd(8'h00, 8'hA0, "R1 lower half untouched");

        // R1: wrap modulo 512
        op(8'h83);
        wr(8'hFE, 8'h10, 8'h77);
        mem_m[9'h010] = 8'h77;
        wait_cycle;
        rd(8'h00, 8'h10, "R1 address wraps");

        // R7: override used once
        op(8'h83);
        wr(8'h00, 8'h20, 8'h11);
        mem_m[9'h020] = 8'h11;
        wait_cycle;
        wr(8'h00, 8'h21, 8'h22);
        wait_cycle;
        rd(8'h00, 8'h20, "R7 first write after override");
        rd(8'h00, 8'h21, "R7 second write blocked");

        // R7: unknown opcode consumes override
        op(8'h83);
        op(8'h55);
        wr(8'h00, 8'h60, 8'h01);
        wait_cycle;
        rd(8'h00, 8'h60, "R7 override consumed by other opcode");

        // R8: status reporting
        op(8'h81);
        check(sdo_oe == 1'b1 && sdo == 1'b1, "R8 ready high when idle", {sdo_oe, sdo}, 3);
        op(8'h83);
        wr(8'h00, 8'h30, 8'h99);
        mem_m[9'h030] = 8'h99;
        check(sdo_oe == 1'b1 && sdo == 1'b0, "R8 busy low at cycle", {sdo_oe, sdo}, 2);
        cnt = 0;
        while (sdo == 1'b0 && cnt < PROG + 50) begin
            tick(1);
            cnt++;
        end
        check(cnt >= PROG - 12 && cnt <= PROG, "R8 busy window length", cnt, PROG);
        check(sdo_oe == 1'b1 && sdo == 1'b1, "R8 ready after cycle", {sdo_oe, sdo}, 3);
        rd(8'h00, 8'h30, "R3 write with status on");

        // R10: frames during a cycle are discarded
        op(8'h83);
        wr(8'h00, 8'h40, 8'hAB);
        mem_m[9'h040] = 8'hAB;
        op(8'h83);
        wr(8'h00, 8'h41, 8'hCD);
        wait_cycle;
        rd(8'h00, 8'h41, "R10 command during cycle ignored");
        rd(8'h00, 8'h40, "R10 earlier write intact");

        // R4: erase with and without override
        op(8'h83);
        cmd3(8'hC0, 8'h00, 8'h05);
        mem_m[9'h005] = 8'hFF;
        wait_cycle;
        rd(8'h00, 8'h05, "R4 erase sets FF");
        cmd3(8'hC0, 8'h00, 8'h10);
        wait_cycle;
        rd(8'h00, 8'h10, "R6 erase blocked");

        // R11: partial frame discarded, next frame aligned
        op(8'h83);
        begin_f;
        put_byte(8'hC1); put_byte(8'h00); put_byte(8'h50);
        for (int i = 0; i < 4; i++) begin
            logic o, e;
            xfer(1'b0, o, e);
        end
        end_f;
        wait_cycle;
        rd(8'h00, 8'h50, "R11 partial write discarded");
        op(8'h83);
        wr(8'h00, 8'h51, 8'h42);
        mem_m[9'h051] = 8'h42;
        wait_cycle;
        rd(8'h00, 8'h51, "R11 next frame aligned");

        // R5: single and interrupted chip clear do nothing
        op(8'h83);
        op(8'h89);
        wait_cycle;
        rd(8'h00, 8'h51, "R5 single entry no effect");
        op(8'h83);
        op(8'h89);
        op(8'h81);
        op(8'h89);
        wait_cycle;
        rd(8'h01, 8'hA0, "R5 interrupted clear no effect");

        // R5: two back-to-back entries clear everything
        op(8'h83);
        op(8'h89);
        op(8'h89);
        for (int i = 0; i < 512; i++) mem_m[i] = 8'hFF;
        wait_cycle;
        rd(8'h00, 8'h51, "R5 chip clear low");
        rd(8'h01, 8'hA0, "R5 chip clear high");
        rd(8'h00, 8'h40, "R5 chip clear other");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule